// File: doc/BRIEF.md
# Embedded Program/Erase Status Generator

This block stands behind the command decoder of a byte-wide flash array model. When the decoder has seen the last write of a byte-program, page-erase or whole-array-erase sequence, it pulses one of three start inputs and presents the target address and data. The block then stays busy for a cycle count set by a parameter for that kind of operation. At the end of that count it writes the result into the array it holds.

While busy, the byte returned on a read is not array data. Bit 7 is a polling flag: it is the inverse of bit 7 of the byte being programmed, or 0 while erasing. Bit 6 is a flag that inverts on each read access, at any address. Bits 5..0 carry the stored byte at the read address. When idle, reads return the stored byte unchanged. The busy output tells the decoder to hold off new commands.

Programming can only clear bits. A page erase sets one page to 0xFF. A whole-array erase sets every page to 0xFF except the pages marked locked.

Top module: `est_status_gen`

## Requirements
- R1: After reset, busy is 0 and every array byte reads as 0xFF.
- R2: A start pulse taken while idle raises busy from the next cycle. Busy then stays high for exactly PROG_CYC cycles for a program, PAGE_CYC for a page erase and CHIP_CYC for a whole-array erase. If several start inputs are high in the same cycle, the whole-array erase wins, then the page erase, then the program.
- R3: Start pulses that arrive while busy is high are ignored. They leave the running operation, its duration and its result unchanged.
- R4: While a program is busy, rd_data[7] is the inverse of bit 7 of the data being programmed, and rd_data[5:0] equal bits 5..0 of the stored byte at rd_addr.
- R5: While an erase of either kind is busy, rd_data[7] is 0.
- R6: rd_data[6] is 0 in the first busy cycle of every operation. It inverts after each cycle in which rd_access is high while busy, and holds otherwise.
- R7: When a program completes, the byte at its address becomes the old value ANDed with the programmed data, so no bit goes from 0 to 1.
- R8: When a page erase completes, every byte whose page number (address bits ADDR_W-1..PAGE_W) equals that of the erase address becomes 0xFF. No other byte changes.
- R9: When a whole-array erase completes, every byte in page p becomes 0xFF if bit p of lock_mask was 0 at the start pulse. Bytes in locked pages keep their values.
- R10: While idle, rd_data equals the stored byte at rd_addr, and rd_access has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_prog | input | 1 | Pulse: final write of a byte program |
| start_page_erase | input | 1 | Pulse: final write of a page erase |
| start_chip_erase | input | 1 | Pulse: final write of a whole-array erase |
| op_addr | input | ADDR_W | Target address (page-select for a page erase) |
| op_data | input | 8 | Byte to program |
| lock_mask | input | 2**(ADDR_W-PAGE_W) | One bit per page; 1 shields the page from a whole-array erase |
| rd_access | input | 1 | High for one cycle per read access (chip or output enable) |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Read byte or status byte |
| busy | output | 1 | Operation in progress |

## Verification
The properties assume that start pulses last one cycle, that rd_access is a single-cycle event per read, and that lock_mask is stable around the start pulse. The polling and toggle properties also rely on the array read being combinational, so rd_data follows rd_addr in the same cycle. The bench drives every start and every read access for exactly one cycle, set on the falling edge. It also injects stray starts in the middle of a busy period, to check that busy and the latched operation hold steady across them.

// File: rtl/est_pkg.sv
package est_pkg;
  typedef enum logic [1:0] {OP_NONE, OP_PROG, OP_PAGE, OP_CHIP} est_op_e;

  // Program can only pull bits low.
  function automatic logic [7:0] prog_merge(input logic [7:0] old_b, input logic [7:0] new_b);
    return old_b & new_b;
  endfunction

  // Polling flag on bit 7 while busy.
  function automatic logic poll_bit(input est_op_e op, input logic [7:0] d);
    return (op == OP_PROG) ? ~d[7] : 1'b0;
  endfunction
endpackage

// File: rtl/est_timer.sv
module est_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             busy,
  output logic             done
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
  assign done = (cnt == CNT_W'(1));
endmodule

// File: rtl/est_toggle.sv
module est_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic adv,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= 1'b0;
    else if (clr)  q <= 1'b0;
    else if (adv)  q <= ~q;
  end
endmodule

// File: rtl/est_array.sv
module est_array import est_pkg::*; #(
  parameter int ADDR_W = 10,
  parameter int PAGE_W = 6
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_prog,
  input  logic                            wr_page,
  input  logic                            wr_chip,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [7:0]                      data,
  input  logic [(1<<(ADDR_W-PAGE_W))-1:0] lock_mask,
  input  logic [ADDR_W-1:0]               rd_addr,
  output logic [7:0]                      rd_q
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PG_W  = ADDR_W - PAGE_W;

  logic [7:0]       mem [DEPTH];
  logic [DEPTH-1:0] erase_hit;
  logic [DEPTH-1:0] prog_hit;

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    localparam logic [PG_W-1:0] PG = PG_W'(g >> PAGE_W);
    assign erase_hit[g] = (wr_page && addr[ADDR_W-1:PAGE_W] == PG) ||
                          (wr_chip && !lock_mask[PG]);
    assign prog_hit[g]  = wr_prog && (addr == ADDR_W'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (erase_hit[i])     mem[i] <= 8'hFF;
        else if (prog_hit[i]) mem[i] <= prog_merge(mem[i], data);
      end
    end
  end

  assign rd_q = mem[rd_addr];
endmodule

// File: rtl/est_status_gen.sv
module est_status_gen import est_pkg::*; #(
  parameter int ADDR_W   = 10,
  parameter int PAGE_W   = 6,
  parameter int PROG_CYC = 40,
  parameter int PAGE_CYC = 150,
  parameter int CHIP_CYC = 400
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            start_prog,
  input  logic                            start_page_erase,
  input  logic                            start_chip_erase,
  input  logic [ADDR_W-1:0]               op_addr,
  input  logic [7:0]                      op_data,
  input  logic [(1<<(ADDR_W-PAGE_W))-1:0] lock_mask,
  input  logic                            rd_access,
  input  logic [ADDR_W-1:0]               rd_addr,
  output logic [7:0]                      rd_data,
  output logic                            busy
);
  localparam int NPAGES  = 1 << (ADDR_W - PAGE_W);
  localparam int MAX_CYC = (CHIP_CYC > PAGE_CYC) ?
                           ((CHIP_CYC > PROG_CYC) ? CHIP_CYC : PROG_CYC) :
                           ((PAGE_CYC > PROG_CYC) ? PAGE_CYC : PROG_CYC);
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  function automatic logic [CNT_W-1:0] dur_of(input est_op_e op);
    case (op)
      OP_CHIP: return CNT_W'(CHIP_CYC);
      OP_PAGE: return CNT_W'(PAGE_CYC);
      default: return CNT_W'(PROG_CYC);
    endcase
  endfunction

  est_op_e             sel_op;
  est_op_e             op_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [7:0]          data_q;
  logic [NPAGES-1:0]   lock_q;
  logic                accept;
  logic                done_evt;
  logic                tog_q;
  logic [7:0]          arr_q;

  always_comb begin
    if (start_chip_erase)      sel_op = OP_CHIP;
    else if (start_page_erase) sel_op = OP_PAGE;
    else if (start_prog)       sel_op = OP_PROG;
    else                       sel_op = OP_NONE;
  end

  assign accept = (sel_op != OP_NONE) && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_NONE;
      addr_q <= '0;
      data_q <= '0;
      lock_q <= '0;
    end else if (accept) begin
      op_q   <= sel_op;
      addr_q <= op_addr;
      data_q <= op_data;
      lock_q <= lock_mask;
    end
  end

  est_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_val(dur_of(sel_op)),
    .busy(busy), .done(done_evt)
  );

  est_toggle u_toggle (
    .clk(clk), .rst_n(rst_n), .clr(accept), .adv(busy && rd_access), .q(tog_q)
  );

  est_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_array (
    .clk(clk), .rst_n(rst_n),
    .wr_prog(done_evt && op_q == OP_PROG),
    .wr_page(done_evt && op_q == OP_PAGE),
    .wr_chip(done_evt && op_q == OP_CHIP),
    .addr(addr_q), .data(data_q), .lock_mask(lock_q),
    .rd_addr(rd_addr), .rd_q(arr_q)
  );

  assign rd_data = busy ? {poll_bit(op_q, data_q), tog_q, arr_q[5:0]} : arr_q;
endmodule

// File: rtl/est_status_chk.sv
module est_status_chk import est_pkg::*; #(
  parameter int PROG_CYC = 40,
  parameter int PAGE_CYC = 150,
  parameter int CHIP_CYC = 400
) (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       accept,
  input logic       done_evt,
  input logic       rd_access,
  input logic [7:0] rd_data,
  input est_op_e    op_q
);
  int run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_len <= 0;
    else if (accept) run_len <= 0;
    else if (busy)   run_len <= run_len + 1;
  end

  function automatic int exp_len(input est_op_e op);
    return (op == OP_CHIP) ? CHIP_CYC : (op == OP_PAGE) ? PAGE_CYC : PROG_CYC;
  endfunction

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy); // R2
  AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |-> (run_len + 1 == exp_len(op_q))); // R2
  AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |-> busy); // R2
  AST_OP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done_evt) |=> $stable(op_q)); // R3
  AST_ERASE_POLL: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_q != OP_PROG) |-> (rd_data[7] == 1'b0)); // R5
  AST_TOG_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (rd_data[6] == 1'b0)); // R6
  AST_TOG_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done_evt && rd_access) |=> (rd_data[6] != $past(rd_data[6]))); // R6
  AST_TOG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done_evt && !rd_access) |=> $stable(rd_data[6])); // R6
endmodule

bind est_status_gen est_status_chk #(
  .PROG_CYC(PROG_CYC), .PAGE_CYC(PAGE_CYC), .CHIP_CYC(CHIP_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .accept(accept), .done_evt(done_evt),
  .rd_access(rd_access), .rd_data(rd_data), .op_q(op_q)
);

// File: tb/tb_est_status_gen.sv
module tb_est_status_gen;
  localparam int ADDR_W = 10, PAGE_W = 6;
  localparam int PROG_CYC = 40, PAGE_CYC = 150, CHIP_CYC = 400;
  localparam int DEPTH = 1 << ADDR_W;
  localparam int NPAGES = 1 << (ADDR_W - PAGE_W);

  logic clk = 0, rst_n = 0;
  logic start_prog = 0, start_page_erase = 0, start_chip_erase = 0;
  logic [ADDR_W-1:0] op_addr = '0, rd_addr = '0;
  logic [7:0] op_data = '0;
  logic [NPAGES-1:0] lock_mask = '0;
  logic rd_access = 0;
  logic [7:0] rd_data;
  logic busy;

  int errors = 0, checks = 0;
  logic [7:0] model [DEPTH];

  always #4 clk = ~clk;

  est_status_gen #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .PROG_CYC(PROG_CYC),
                   .PAGE_CYC(PAGE_CYC), .CHIP_CYC(CHIP_CYC)) dut (
    .clk(clk), .rst_n(rst_n), .start_prog(start_prog), .start_page_erase(start_page_erase),
    .start_chip_erase(start_chip_erase), .op_addr(op_addr), .op_data(op_data),
    .lock_mask(lock_mask), .rd_access(rd_access), .rd_addr(rd_addr),
    .rd_data(rd_data), .busy(busy));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // kind bits: 0 program, 1 page erase, 2 whole-array erase
  function automatic int kind_of(input logic [2:0] k);
    return k[2] ? 2 : k[1] ? 1 : 0;
  endfunction

  function automatic int dur_of(input int kind);
    return (kind == 2) ? CHIP_CYC : (kind == 1) ? PAGE_CYC : PROG_CYC;
  endfunction

  task automatic apply_model(input int kind, input logic [ADDR_W-1:0] a,
                             input logic [7:0] d, input logic [NPAGES-1:0] lk);
    for (int i = 0; i < DEPTH; i++) begin
      if (kind == 2 && !lk[i / (1 << PAGE_W)]) model[i] = 8'hFF;
      if (kind == 1 && (i / (1 << PAGE_W)) == int'(a) / (1 << PAGE_W)) model[i] = 8'hFF;
    end
    if (kind == 0) model[a] = model[a] & d;
  endtask

  task automatic run_op(input logic [2:0] kmask, input logic [ADDR_W-1:0] a,
                        input logic [7:0] d, input logic [NPAGES-1:0] lk,
                        input string rq_done);
    int kind = kind_of(kmask);
    int n = 0;
    logic exp_tog = 1'b0;
    logic exp7 = (kind == 0) ? ~d[7] : 1'b0;
    @(negedge clk);
    {start_chip_erase, start_page_erase, start_prog} = kmask;
    op_addr = a; op_data = d; lock_mask = lk;
    forever begin
      @(negedge clk);
      {start_chip_erase, start_page_erase, start_prog} = 3'b000;
      if (n == 3) begin  // stray start while busy (R3)
        start_prog = 1'b1; start_chip_erase = 1'b1;
        op_addr = a ^ ADDR_W'(1); op_data = 8'h00; lock_mask = '0;
      end
      rd_addr = ADDR_W'($urandom % DEPTH);
      rd_access = 1'($urandom % 2);
      #1;
      if (!busy) break;
      n++;
      check(kind == 0 ? "R4 poll" : "R5 poll", rd_data[7], exp7);
      check("R6 toggle", rd_data[6], exp_tog);
      if (kind == 0) check("R4 low bits", rd_data[5:0], model[rd_addr][5:0]);
      if (rd_access) exp_tog = ~exp_tog;
    end
    start_prog = 0; start_chip_erase = 0;
    rd_access = 0;
    check("R2 R3 busy length", n, dur_of(kind));
    apply_model(kind, a, d, lk);
    check_all(rq_done);
  endtask

  task automatic check_all(input string rq);
    int bad = 0;
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      rd_addr = ADDR_W'(i);
      rd_access = 1'($urandom % 2);  // R10: no effect when idle
      #1;
      if (rd_data !== model[i]) begin
        if (bad < 4) $display("FAIL %s R10 addr %0h: actual=%0h expected=%0h", rq, i, rd_data, model[i]);
        bad++;
      end
    end
    rd_access = 0;
    checks++;
    if (bad != 0) errors++;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    check("R1 busy", busy, 1'b0);
    check_all("R1");
    run_op(3'b001, 10'h005, 8'h5A, '0, "R7");
    run_op(3'b001, 10'h005, 8'h0F, '0, "R7");   // 0x5A & 0x0F = 0x0A
    @(negedge clk); rd_addr = 10'h005; #1;
    check("R7 only clears", rd_data, 8'h0A);
    run_op(3'b001, 10'h3FF, 8'hC3, '0, "R7");
    run_op(3'b001, 10'h041, 8'h00, '0, "R7");
    run_op(3'b010, 10'h023, 8'h00, '0, "R8");   // page 0
    @(negedge clk); rd_addr = 10'h041; #1;
    check("R8 other page kept", rd_data, 8'h00);
    for (int r = 0; r < 12; r++)
      run_op(3'b001, ADDR_W'($urandom % DEPTH), 8'($urandom), '0, "R7");
    run_op(3'b001, 10'h080, 8'h11, '0, "R7");
    run_op(3'b001, 10'h100, 8'h22, '0, "R7");
    run_op(3'b011, 10'h090, 8'h00, '0, "R2 priority R8");  // page erase wins
    run_op(3'b101, 10'h000, 8'h00, 16'h00F4, "R2 priority R9");
    @(negedge clk); rd_addr = 10'h080; #1;
    check("R9 locked page kept", rd_data, model[10'h080]);
    run_op(3'b100, 10'h000, 8'h00, '0, "R9");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule